// File: doc/BRIEF.md
# Microsecond Timer with Alarm Comparators

This block is a register-mapped timer. It keeps a free-running 64-bit count of microseconds and compares that count against four alarm channels. A tick divider splits the reference clock by a programmable number of cycles, one microsecond per tick, so that number should match the reference frequency in MHz. The count advances by one on each tick unless the halt bit is set.

Software accesses the block over a 32-bit word bus. A read returns its data one cycle after the read strobe. The 64-bit count is read and written as two 32-bit halves:
- Reading the snapshot low word also captures the high word, so the following snapshot high read is consistent with it.
- Writing the count takes two steps. The first write stages the low word. The second write supplies the high word and loads all 64 bits at once.

Each alarm holds a 32-bit target that is compared only with the low half of the count. Writing a target arms the channel. When the channel fires, it disarms itself and sets a sticky raw interrupt bit. Each interrupt output is that raw bit gated by its enable bit.

Top module: `usec_alarm_timer`

## Requirements
- R1: After reset the count is zero. On every tick while not halted, the count advances by exactly one.
- R2: The divisor register (word 15, bits 7:0) resets to 1 and produces one tick every divisor clock cycles. A value of 0 behaves as 1.
- R3: While the halt register (word 11, bit 0) holds 1, the count keeps its value.
- R4: Reading word 2 returns count bits 31:0 and captures bits 63:32. The next read of word 3 returns the captured value and releases the capture. Any later read of word 3 returns the live bits 63:32 until word 2 is read again.
- R5: Words 4 and 5 return count bits 31:0 and 63:32 directly. Reading them does not change what word 3 returns.
- R6: Writing word 0 stages a low value and leaves the count unchanged. Writing word 1 loads the count with {written value, staged low value}.
- R7: Writing alarm word 6+i (i = 0..3) stores the target and sets armed bit i (word 10). The target reads back at the same word. Rewriting the same value arms the channel again.
- R8: An armed channel fires on the cycle where the count advances to a value whose bits 31:0 equal its target, whatever bits 63:32 hold. Firing clears armed bit i and sets raw bit i (word 12).
- R9: Writing 1 to bit i of word 10 disarms channel i without setting its raw bit. Writing 0 to a bit has no effect.
- R10: A raw bit stays set until a 1 is written to it in word 12. Writing 0 to it has no effect.
- R11: irq_o[i] equals raw bit i AND enable bit i (word 13). Word 14 reads back those four AND results.
- R12: After reset, armed, halt, enable and raw all read 0, and every alarm target reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_o | output | 4 | Per-channel interrupt, raw AND enable |

## Verification
The assertions check the following on every cycle:
- The count steps by exactly one on an advance and holds while halted.
- A firing channel both disarms itself and sets its raw bit.
- A raw bit never drops without a write-one clear.
- The armed bit rises only after a target write.
- An interrupt is never raised without its enable bit.

Only the bench scenarios can show the following:
- The capture-and-release behaviour of the two count reads.
- The staged two-step write.
- The exact tick rate for a chosen divisor.
- That the high count bits are ignored by the compare.
- That a disarmed or halted channel stays silent.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    localparam int HALF_W  = 32;
    localparam int CNT_W   = 2 * HALF_W;
    localparam int N_ALARM = 4;
    localparam int ADDR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_STAGE_LO  = 4'd0,
        RA_COMMIT_HI = 4'd1,
        RA_SNAP_LO   = 4'd2,
        RA_SNAP_HI   = 4'd3,
        RA_LIVE_LO   = 4'd4,
        RA_LIVE_HI   = 4'd5,
        RA_ALARM0    = 4'd6,
        RA_ALARM1    = 4'd7,
        RA_ALARM2    = 4'd8,
        RA_ALARM3    = 4'd9,
        RA_ARMED     = 4'd10,
        RA_HALT      = 4'd11,
        RA_RAW       = 4'd12,
        RA_ENABLE    = 4'd13,
        RA_MASKED    = 4'd14,
        RA_TICKDIV   = 4'd15
    } reg_addr_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hits(bus_req_t r, reg_addr_e a);
        return r.addr == a;
    endfunction

    function automatic logic [ADDR_W-1:0] alarm_addr(int idx);
        return ADDR_W'(int'(RA_ALARM0) + idx);
    endfunction

endpackage

// File: rtl/usec_tick_div.sv
module usec_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;
    logic             wrap;

    // a divisor of 0 or 1 gives a tick on every cycle
    assign wrap   = (div_i <= DIV_W'(1)) || (phase_q >= div_i - DIV_W'(1));
    assign tick_o = wrap;

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (wrap) phase_q <= '0;
        else           phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/usec_counter64.sv
module usec_counter64
    import usec_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              stage_we_i,
    input  logic              commit_we_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              snap_lo_re_i,
    input  logic              snap_hi_re_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [HALF_W-1:0] snap_hi_o
);
    logic [CNT_W-1:0]  count_q;
    logic [HALF_W-1:0] staged_q;
    logic [HALF_W-1:0] held_q;
    logic              holding_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            staged_q  <= '0;
            held_q    <= '0;
            holding_q <= 1'b0;
        end else begin
            if (stage_we_i)       staged_q <= wdata_i;
            if (commit_we_i)      count_q  <= {wdata_i, staged_q};
            else if (adv_i)       count_q  <= count_q + CNT_W'(1);
            if (snap_lo_re_i) begin
                held_q    <= count_q[CNT_W-1:HALF_W];
                holding_q <= 1'b1;
            end else if (snap_hi_re_i) begin
                holding_q <= 1'b0;
            end
        end
    end

    assign count_o   = count_q;
    assign snap_hi_o = holding_q ? held_q : count_q[CNT_W-1:HALF_W];
endmodule

// File: rtl/usec_alarm_bank.sv
module usec_alarm_bank
    import usec_timer_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           adv_i,
    input  logic [HALF_W-1:0]              next_lo_i,
    input  logic [N_ALARM-1:0]             arm_we_i,
    input  logic [HALF_W-1:0]              wdata_i,
    input  logic [N_ALARM-1:0]             disarm_i,
    input  logic [N_ALARM-1:0]             raw_clr_i,
    output logic [N_ALARM-1:0][HALF_W-1:0] target_o,
    output logic [N_ALARM-1:0]             armed_o,
    output logic [N_ALARM-1:0]             raw_o,
    output logic [N_ALARM-1:0]             fire_o
);
    for (genvar i = 0; i < N_ALARM; i++) begin : g_ch
        logic [HALF_W-1:0] tgt_q;
        logic              armed_q;
        logic              raw_q;
        logic              fire;

        // a write to the target or to the disarm bit wins over a match
        assign fire = armed_q && adv_i && (next_lo_i == tgt_q)
                      && !disarm_i[i] && !arm_we_i[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                tgt_q   <= '0;
                armed_q <= 1'b0;
                raw_q   <= 1'b0;
            end else begin
                if (arm_we_i[i])              tgt_q   <= wdata_i;
                if (arm_we_i[i])              armed_q <= 1'b1;
                else if (disarm_i[i] || fire) armed_q <= 1'b0;
                if (fire)                     raw_q   <= 1'b1;
                else if (raw_clr_i[i])        raw_q   <= 1'b0;
            end
        end

        assign target_o[i] = tgt_q;
        assign armed_o[i]  = armed_q;
        assign raw_o[i]    = raw_q;
        assign fire_o[i]   = fire;
    end
endmodule

// File: rtl/usec_alarm_timer.sv
module usec_alarm_timer
    import usec_timer_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [HALF_W-1:0] bus_rdata,
    output logic [N_ALARM-1:0] irq_o
);
    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(1);

    bus_req_t req;
    assign req = '{we: bus_we, re: bus_re, addr: bus_addr, wdata: bus_wdata};

    logic                           halt_q;
    logic [N_ALARM-1:0]             en_q;
    logic [DIV_W-1:0]               div_q;
    logic [HALF_W-1:0]              rdata_q;
    logic                           tick;
    logic                           adv;
    logic                           commit;
    logic [CNT_W-1:0]               count;
    logic [HALF_W-1:0]              snap_hi;
    logic [N_ALARM-1:0]             arm_we;
    logic [N_ALARM-1:0]             disarm;
    logic [N_ALARM-1:0]             raw_clr;
    logic [N_ALARM-1:0][HALF_W-1:0] target;
    logic [N_ALARM-1:0]             armed;
    logic [N_ALARM-1:0]             raw;
    logic [N_ALARM-1:0]             fire;
    logic [HALF_W-1:0]              next_lo;

    assign commit  = req.we && hits(req, RA_COMMIT_HI);
    assign adv     = tick && !halt_q && !commit;
    assign next_lo = count[HALF_W-1:0] + HALF_W'(1);
    assign disarm  = (req.we && hits(req, RA_ARMED)) ? req.wdata[N_ALARM-1:0] : '0;
    assign raw_clr = (req.we && hits(req, RA_RAW))   ? req.wdata[N_ALARM-1:0] : '0;

    for (genvar i = 0; i < N_ALARM; i++) begin : g_arm
        assign arm_we[i] = req.we && (req.addr == alarm_addr(i));
    end

    usec_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_q),
        .tick_o (tick)
    );

    usec_counter64 u_cnt (
        .clk          (clk),
        .rst          (rst),
        .adv_i        (adv),
        .stage_we_i   (req.we && hits(req, RA_STAGE_LO)),
        .commit_we_i  (commit),
        .wdata_i      (req.wdata),
        .snap_lo_re_i (req.re && hits(req, RA_SNAP_LO)),
        .snap_hi_re_i (req.re && hits(req, RA_SNAP_HI)),
        .count_o      (count),
        .snap_hi_o    (snap_hi)
    );

    usec_alarm_bank u_alm (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (adv),
        .next_lo_i (next_lo),
        .arm_we_i  (arm_we),
        .wdata_i   (req.wdata),
        .disarm_i  (disarm),
        .raw_clr_i (raw_clr),
        .target_o  (target),
        .armed_o   (armed),
        .raw_o     (raw),
        .fire_o    (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            en_q   <= '0;
            div_q  <= DIV_RESET;
        end else if (req.we) begin
            if (hits(req, RA_HALT))    halt_q <= req.wdata[0];
            if (hits(req, RA_ENABLE))  en_q   <= req.wdata[N_ALARM-1:0];
            if (hits(req, RA_TICKDIV)) div_q  <= req.wdata[DIV_W-1:0];
        end
    end

    logic [HALF_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (req.addr)
            RA_SNAP_LO, RA_LIVE_LO: rd_mux = count[HALF_W-1:0];
            RA_SNAP_HI:             rd_mux = snap_hi;
            RA_LIVE_HI:             rd_mux = count[CNT_W-1:HALF_W];
            RA_ALARM0:              rd_mux = target[0];
            RA_ALARM1:              rd_mux = target[1];
            RA_ALARM2:              rd_mux = target[2];
            RA_ALARM3:              rd_mux = target[3];
            RA_ARMED:               rd_mux = HALF_W'(armed);
            RA_HALT:                rd_mux = HALF_W'(halt_q);
            RA_RAW:                 rd_mux = HALF_W'(raw);
            RA_ENABLE:              rd_mux = HALF_W'(en_q);
            RA_MASKED:              rd_mux = HALF_W'(raw & en_q);
            RA_TICKDIV:             rd_mux = HALF_W'(div_q);
            default:                rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = raw & en_q;
endmodule

// File: rtl/usec_alarm_timer_chk.sv
module usec_alarm_timer_chk
    import usec_timer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               adv,
    input logic               halt_q,
    input logic               commit,
    input logic [CNT_W-1:0]   count,
    input logic [N_ALARM-1:0] armed,
    input logic [N_ALARM-1:0] raw,
    input logic [N_ALARM-1:0] en_q,
    input logic [N_ALARM-1:0] irq_o,
    input logic [N_ALARM-1:0] fire,
    input logic [N_ALARM-1:0] arm_we,
    input logic [N_ALARM-1:0] raw_clr
);
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(adv) && !$past(commit) |-> count == $past(count) + CNT_W'(1)); // R1

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(halt_q) && !$past(commit) |-> $stable(count)); // R3

    for (genvar i = 0; i < N_ALARM; i++) begin : g_ch
        AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
            fire[i] |=> !armed[i] && raw[i]); // R8

        AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(raw[i]) && !$past(raw_clr[i]) |-> raw[i]); // R10

        AST_ARM_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $rose(armed[i]) |-> $past(arm_we[i])); // R7

        AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> en_q[i] && raw[i]); // R11
    end
endmodule

bind usec_alarm_timer usec_alarm_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .halt_q  (halt_q),
    .commit  (commit),
    .count   (count),
    .armed   (armed),
    .raw     (raw),
    .en_q    (en_q),
    .irq_o   (irq_o),
    .fire    (fire),
    .arm_we  (arm_we),
    .raw_clr (raw_clr)
);

// File: tb/usec_alarm_timer_test.sv
module usec_alarm_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    localparam logic [3:0] A_STAGE = 4'd0, A_COMMIT = 4'd1, A_SLO = 4'd2, A_SHI = 4'd3,
                           A_LLO = 4'd4, A_LHI = 4'd5, A_AL0 = 4'd6, A_ARMED = 4'd10,
                           A_HALT = 4'd11, A_RAW = 4'd12, A_EN = 4'd13, A_MASK = 4'd14,
                           A_DIV = 4'd15;

    usec_alarm_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic load(logic [31:0] hi, logic [31:0] lo);
        wr(A_STAGE, lo);
        wr(A_COMMIT, hi);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_ARMED, v);  chk("R12 armed", v, 0);
        rd(A_HALT, v);   chk("R12 halt", v, 0);
        rd(A_EN, v);     chk("R12 enable", v, 0);
        rd(A_RAW, v);    chk("R12 raw", v, 0);
        rd(A_AL0, v);    chk("R12 target0", v, 0);
        rd(A_DIV, v);    chk("R2 divisor reset", v, 1);
        rd(A_LHI, v);    chk("R1 high after reset", v, 0);
        chk("R11 irq after reset", 32'(irq_o), 0);
    endtask

    task automatic t_step;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(0, 32'h40);
        wr(A_HALT, 0);
        idle(9);
        wr(A_HALT, 1);
        rd(A_LLO, v);  chk("R1 ten steps", v, 32'h4A);
    endtask

    task automatic t_halt_and_write;
        logic [31:0] a, b;
        wr(A_HALT, 1);
        load(32'h12345678, 32'hDEADBEEF);
        rd(A_LLO, a);  chk("R6 loaded low", a, 32'hDEADBEEF);
        rd(A_LHI, a);  chk("R6 loaded high", a, 32'h12345678);
        wr(A_STAGE, 32'h11);
        rd(A_LLO, a);  chk("R6 stage alone", a, 32'hDEADBEEF);
        rd(A_LLO, a);
        idle(10);
        rd(A_LLO, b);  chk("R3 halted count", b, a);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(5, 32'hFFFF_FFF0);
        wr(A_HALT, 0);
        rd(A_SLO, v);  chk("R4 low before wrap", 32'(v >= 32'hFFFF_FFF0), 1);
        idle(30);
        rd(A_SHI, v);  chk("R4 captured high", v, 5);
        rd(A_SHI, v);  chk("R4 released high", v, 6);
        rd(A_LLO, v);
        rd(A_SHI, v);  chk("R5 live read no capture", v, 6);
    endtask

    task automatic t_divider;
        logic [31:0] a, b;
        wr(A_HALT, 0);
        wr(A_DIV, 10);
        idle(3);
        rd(A_LLO, a);
        idle(99);
        rd(A_LLO, b);  chk("R2 ticks in 100 cycles", b - a, 10);
        wr(A_DIV, 1);
    endtask

    task automatic t_fire;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(0, 100);
        wr(A_AL0, 110);
        rd(A_ARMED, v); chk("R7 arm on write", v & 1, 1);
        rd(A_AL0, v);   chk("R7 target readback", v, 110);
        wr(A_EN, 1);
        wr(A_HALT, 0);
        idle(20);
        chk("R11 irq0 raised", 32'(irq_o), 1);
        rd(A_ARMED, v); chk("R8 self disarm", v & 1, 0);
        rd(A_RAW, v);   chk("R8 raw set", v, 1);
        rd(A_MASK, v);  chk("R11 masked set", v, 1);
        wr(A_EN, 0);
        idle(1);
        chk("R11 irq0 masked off", 32'(irq_o), 0);
        rd(A_MASK, v);  chk("R11 masked clear", v, 0);
        wr(A_RAW, 0);
        rd(A_RAW, v);   chk("R10 zero write ignored", v, 1);
        wr(A_RAW, 1);
        rd(A_RAW, v);   chk("R10 one clears", v, 0);
        // rearm with the same target
        wr(A_HALT, 1);
        load(0, 100);
        wr(A_AL0, 110);
        wr(A_HALT, 0);
        idle(20);
        rd(A_RAW, v);   chk("R7 rewrite rearms", v, 1);
        wr(A_RAW, 1);
    endtask

    task automatic t_high_ignored;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(7, 500);
        wr(A_AL0 + 4'd2, 505);
        wr(A_HALT, 0);
        idle(15);
        rd(A_RAW, v);   chk("R8 high bits ignored", v, 4);
        wr(A_RAW, 4);
    endtask

    task automatic t_disarm;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(0, 1000);
        wr(A_AL0 + 4'd1, 1010);
        wr(A_ARMED, 0);
        rd(A_ARMED, v); chk("R9 zero write ignored", v, 2);
        wr(A_ARMED, 2);
        rd(A_ARMED, v); chk("R9 disarmed", v, 0);
        wr(A_HALT, 0);
        idle(20);
        rd(A_RAW, v);   chk("R9 no fire after disarm", v, 0);
    endtask

    task automatic t_halt_blocks;
        logic [31:0] v;
        wr(A_HALT, 1);
        load(0, 2000);
        wr(A_AL0 + 4'd3, 2005);
        idle(20);
        rd(A_RAW, v);   chk("R3 halted no fire", v, 0);
        rd(A_ARMED, v); chk("R3 still armed", v, 8);
        wr(A_HALT, 0);
        idle(20);
        rd(A_RAW, v);   chk("R8 fires after resume", v, 8);
        wr(A_RAW, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_step;
        t_halt_and_write;
        t_snapshot;
        t_divider;
        t_fire;
        t_high_ignored;
        t_disarm;
        t_halt_blocks;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule